// File: doc/BRIEF.md
# Streaming Receive Buffer Channel

This block takes in a continuous stream of data words that has no packet boundaries. Each word carries a bus address. Words whose address equals the channel's programmed bus address are written one after another into a dual-port RAM buffer. The buffer starts at a programmed base address and holds a programmed number of words. When the buffer fills, the channel raises an interrupt. It also raises an interrupt when the stream goes quiet before the buffer is full. The interrupt cause says which of the two events happened, and a count output says how many words are in the buffer.

The processor responds by reading the buffer and pulsing an acknowledge. The channel then fills the buffer again from its first word. While an interrupt is pending, the channel holds its ready output low, so the sender stalls and no stored word is overwritten.

The quiet period is set as a number of consecutive cycles without an accepted word. Loading a new configuration rearms the channel in any state.

Top module: `strm_rx_chan`

## Requirements
- R1: After reset the channel is disarmed. `in_ready`, `irq` and `mem_we` are low, `irq_cause` is 0 and `word_count` is 0.
- R2: A `cfg_load` pulse latches the bus address, base, length and idle limit, and clears any pending event. A length of at least 1 arms the channel, so `in_ready` is high from the next cycle. A length of 0 leaves it disarmed: `in_ready` stays low and no word is written.
- R3: A word is accepted when `in_valid`, `in_ready` and an address match all hold. An accepted word is written in the same cycle to `mem_addr` = base + k, where k counts accepted words from 0. `mem_wdata` equals `in_data`.
- R4: A word whose `in_addr` differs from the programmed bus address is ignored. It causes no write and does not advance the write offset.
- R5: In the cycle after the word that fills the buffer (word number `length`) is accepted, `irq` goes high with `irq_cause` = 1 (full) and `word_count` = length.
- R6: Suppose at least one word is stored and the idle limit L is not 0. After L consecutive cycles with no accepted word, `irq` goes high with `irq_cause` = 2 (idle) and `word_count` = the number of stored words. An L of 0 disables the timeout. The timer does not run while the buffer is empty.
- R7: While `irq` is high, `in_ready` is low and no memory write occurs.
- R8: `ack` while `irq` is high clears `irq` and raises `in_ready` on the next cycle. The next accepted word is then written at the base address. `ack` while no interrupt is pending is ignored.
- R9: `irq`, `irq_cause` and `word_count` hold steady until `ack` or `cfg_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Latch configuration and (re)arm |
| cfg_bus_addr | input | BW | Bus address this channel listens on |
| cfg_base | input | AW | Buffer base address in RAM |
| cfg_len | input | CW | Buffer size in words |
| cfg_idle | input | IW | Idle cycles before timeout (0 = off) |
| in_valid | input | 1 | Incoming word valid |
| in_addr | input | BW | Bus address of incoming word |
| in_data | input | DW | Incoming data word |
| in_ready | output | 1 | Channel can accept a word |
| mem_we | output | 1 | RAM write strobe |
| mem_addr | output | AW | RAM write address |
| mem_wdata | output | DW | RAM write data |
| irq | output | 1 | Interrupt, level, held until acknowledge |
| irq_cause | output | 2 | 0 none, 1 full, 2 idle |
| word_count | output | CW | Words stored at interrupt |
| ack | input | 1 | Processor acknowledge |

## Verification
The bench checks the exact cycle of an idle timeout: the cycle just before the limit must show no interrupt. An off-by-one timer would fire a cycle early or late. It sends words with a foreign address before the real ones and then checks where the first real word landed, which catches an offset that advances on an address mismatch. It keeps `in_valid` high while an interrupt is pending, to catch a design that overwrites the buffer or lowers the interrupt. It pulses `ack` in the middle of filling, to catch a pointer that restarts without a pending event. It also covers a zero idle limit, which must never time out, and a zero length, which must stay disarmed.

// File: rtl/strm_rx_pkg.sv
package strm_rx_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_FILL = 2'd1,
        ST_WAIT = 2'd2
    } chan_st_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_FULL = 2'd1,
        CAUSE_IDLE = 2'd2
    } cause_e;

    typedef struct packed {
        chan_st_e st;
        cause_e   cause;
    } chan_ctl_t;

endpackage

// File: rtl/strm_rx_wptr.sv
module strm_rx_wptr #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          adv,
    input  logic [AW-1:0] base,
    output logic [CW-1:0] ptr,
    output logic [AW-1:0] addr
);
    localparam logic [CW-1:0] STEP = CW'(1);

    always_ff @(posedge clk) begin
        if (rst || clear) ptr <= '0;
        else if (adv)     ptr <= ptr + STEP;
    end

    assign addr = base + AW'(ptr);
endmodule

// File: rtl/strm_rx_idle.sv
module strm_rx_idle #(
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [IW-1:0] limit,
    output logic          expire
);
    localparam logic [IW-1:0] STEP = IW'(1);
    logic [IW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else             cnt <= cnt + STEP;
    end

    assign expire = run && (limit != '0) && (cnt == limit - STEP);
endmodule

// File: rtl/strm_rx_chan.sv
module strm_rx_chan
    import strm_rx_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int BW = 16,
    parameter int CW = 8,
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_load,
    input  logic [BW-1:0] cfg_bus_addr,
    input  logic [AW-1:0] cfg_base,
    input  logic [CW-1:0] cfg_len,
    input  logic [IW-1:0] cfg_idle,
    input  logic          in_valid,
    input  logic [BW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          irq,
    output logic [1:0]    irq_cause,
    output logic [CW-1:0] word_count,
    input  logic          ack
);
    localparam logic [CW-1:0] ONE = CW'(1);

    chan_ctl_t     ctl;
    logic [BW-1:0] bus_q;
    logic [AW-1:0] base_q;
    logic [CW-1:0] len_q;
    logic [IW-1:0] idle_q;
    logic [CW-1:0] ptr;
    logic          accept, last_word, expire, ptr_clear, idle_run, resume;

    assign in_ready  = (ctl.st == ST_FILL);
    assign accept    = in_ready && in_valid && (in_addr == bus_q);
    assign last_word = accept && (ptr == len_q - ONE);
    assign resume    = (ctl.st == ST_WAIT) && ack;
    assign ptr_clear = cfg_load || resume;
    assign idle_run  = in_ready && !accept && (ptr != '0);

    strm_rx_wptr #(.AW(AW), .CW(CW)) u_wptr (
        .clk   (clk),
        .rst   (rst),
        .clear (ptr_clear),
        .adv   (accept && !cfg_load),
        .base  (base_q),
        .ptr   (ptr),
        .addr  (mem_addr)
    );

    strm_rx_idle #(.IW(IW)) u_idle (
        .clk    (clk),
        .rst    (rst),
        .run    (idle_run && !cfg_load),
        .limit  (idle_q),
        .expire (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl.st     <= ST_OFF;
            ctl.cause  <= CAUSE_NONE;
            word_count <= '0;
            bus_q      <= '0;
            base_q     <= '0;
            len_q      <= '0;
            idle_q     <= '0;
        end else if (cfg_load) begin
            bus_q      <= cfg_bus_addr;
            base_q     <= cfg_base;
            len_q      <= cfg_len;
            idle_q     <= cfg_idle;
            ctl.st     <= (cfg_len != '0) ? ST_FILL : ST_OFF;
            ctl.cause  <= CAUSE_NONE;
            word_count <= '0;
        end else begin
            unique case (ctl.st)
                ST_FILL: begin
                    if (last_word) begin
                        ctl.st     <= ST_WAIT;
                        ctl.cause  <= CAUSE_FULL;
                        word_count <= len_q;
                    end else if (expire) begin
                        ctl.st     <= ST_WAIT;
                        ctl.cause  <= CAUSE_IDLE;
                        word_count <= ptr;
                    end
                end
                ST_WAIT: begin
                    if (ack) begin
                        ctl.st    <= ST_FILL;
                        ctl.cause <= CAUSE_NONE;
                    end
                end
                default: ctl.st <= ST_OFF;
            endcase
        end
    end

    assign mem_we    = accept;
    assign mem_wdata = in_data;
    assign irq       = (ctl.st == ST_WAIT);
    assign irq_cause = ctl.cause;
endmodule

// File: rtl/strm_rx_chk.sv
module strm_rx_chk #(
    parameter int BW = 16,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          ack,
    input logic          cfg_load,
    input logic [BW-1:0] in_addr,
    input logic [BW-1:0] bus_q,
    input logic          mem_we,
    input logic          in_ready,
    input logic          irq,
    input logic [1:0]    irq_cause,
    input logic [CW-1:0] word_count
);
    p_no_write_pending_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (!mem_we && !in_ready));

    p_addr_filter_r4: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (in_addr == bus_q));

    p_write_needs_ready_r2: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> !mem_we);

    p_irq_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (irq && !ack && !cfg_load) |=> (irq && $stable(irq_cause) && $stable(word_count)));

    p_ack_resume_r8: assert property (@(posedge clk) disable iff (rst)
        (irq && ack && !cfg_load) |=> (!irq && in_ready));

    p_cause_set_r5: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((irq_cause == 2'd1 || irq_cause == 2'd2) && word_count != '0));

    p_no_cause_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !irq |-> (irq_cause == 2'd0));
endmodule

bind strm_rx_chan strm_rx_chk #(.BW(BW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ack        (ack),
    .cfg_load   (cfg_load),
    .in_addr    (in_addr),
    .bus_q      (bus_q),
    .mem_we     (mem_we),
    .in_ready   (in_ready),
    .irq        (irq),
    .irq_cause  (irq_cause),
    .word_count (word_count)
);

// File: tb/strm_rx_chan_bench.sv
`timescale 1ns/1ps
module strm_rx_chan_bench;
    localparam int AW = 16, DW = 32, BW = 16, CW = 8, IW = 8;
    localparam logic [BW-1:0] MYBUS = 16'h0042;
    localparam int NV = 5;
    // n[31:24] len[23:16] limit[15:8] expected cause[7:0]
    localparam logic [31:0] VEC [NV] = '{
        32'h04_04_05_01,
        32'h03_08_02_02,
        32'h01_06_01_02,
        32'h06_06_03_01,
        32'h05_10_07_02
    };

    logic clk = 0, rst = 1;
    logic cfg_load = 0;
    logic [BW-1:0] cfg_bus_addr = '0;
    logic [AW-1:0] cfg_base = '0;
    logic [CW-1:0] cfg_len = '0;
    logic [IW-1:0] cfg_idle = '0;
    logic in_valid = 0;
    logic [BW-1:0] in_addr = '0;
    logic [DW-1:0] in_data = '0;
    logic ack = 0;
    logic in_ready, mem_we, irq;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [1:0] irq_cause;
    logic [CW-1:0] word_count;

    int checks = 0, fails = 0, wr_cnt = 0, cycles = 0;
    logic [DW-1:0] cap [256];

    always #10 clk = ~clk;

    strm_rx_chan #(.AW(AW), .DW(DW), .BW(BW), .CW(CW), .IW(IW)) u_strm_rx_chan (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_bus_addr(cfg_bus_addr),
        .cfg_base(cfg_base), .cfg_len(cfg_len), .cfg_idle(cfg_idle),
        .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data),
        .in_ready(in_ready), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .irq(irq), .irq_cause(irq_cause),
        .word_count(word_count), .ack(ack)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            cap[mem_addr[7:0]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_cfg(input logic [BW-1:0] b, input logic [AW-1:0] base,
                          input logic [CW-1:0] len, input logic [IW-1:0] lim);
        cfg_bus_addr = b; cfg_base = base; cfg_len = len; cfg_idle = lim;
        cfg_load = 1;
        @(negedge clk);
        cfg_load = 0;
    endtask

    task automatic push(input logic [BW-1:0] a, input logic [DW-1:0] d);
        in_valid = 1; in_addr = a; in_data = d;
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic pulse_ack();
        ack = 1;
        @(negedge clk);
        ack = 0;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int snap;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", in_ready, 0);
        chk("R1 irq", irq, 0);
        chk("R1 mem_we", mem_we, 0);
        chk("R1 cause", irq_cause, 0);
        chk("R1 count", word_count, 0);

        // R2 zero length stays disarmed
        do_cfg(MYBUS, 16'h00C0, 0, 3);
        chk("R2 zero-len ready", in_ready, 0);
        snap = wr_cnt;
        push(MYBUS, 32'hDEAD0000);
        @(negedge clk);
        chk("R2 zero-len no write", wr_cnt - snap, 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            int n, len, lim, cause;
            logic [AW-1:0] base;
            n = int'(VEC[i][31:24]); len = int'(VEC[i][23:16]);
            lim = int'(VEC[i][15:8]); cause = int'(VEC[i][7:0]);
            base = AW'(16 * i);
            do_cfg(MYBUS, base, CW'(len), IW'(lim));
            chk("R2 armed", in_ready, 1);
            snap = wr_cnt;
            for (int j = 0; j < n; j++) push(MYBUS, {8'hA0 + 8'(i), 24'(j)});
            if (cause == 2) begin
                repeat (lim - 1) @(negedge clk);
                chk("R6 not yet", irq, 0);
                @(negedge clk);
            end
            chk("R5/R6 irq", irq, 1);
            chk("R5/R6 cause", irq_cause, 64'(cause));
            chk("R5/R6 count", word_count, 64'(n));
            chk("R7 ready low", in_ready, 0);
            chk("R3 writes", wr_cnt - snap, 64'(n));
            for (int j = 0; j < n; j++)
                chk("R3 data", cap[8'(base) + 8'(j)], {8'hA0 + 8'(i), 24'(j)});
            pulse_ack();
            chk("R8 irq cleared", irq, 0);
            chk("R8 ready", in_ready, 1);
        end

        // R6 no timeout while empty
        do_cfg(MYBUS, 16'h0080, 4, 2);
        repeat (10) @(negedge clk);
        chk("R6 empty no timeout", irq, 0);
        // R4 foreign words ignored
        snap = wr_cnt;
        push(16'h0066, 32'h11110000);
        push(16'h0066, 32'h11110001);
        chk("R4 no write", wr_cnt - snap, 0);
        push(MYBUS, 32'h22220000);
        push(MYBUS, 32'h22220001);
        push(MYBUS, 32'h22220002);
        push(MYBUS, 32'h22220003);
        chk("R4 first at base", cap[8'h80], 32'h22220000);
        chk("R5 full", irq_cause, 1);
        // R7 valid while pending
        snap = wr_cnt;
        in_valid = 1; in_addr = MYBUS; in_data = 32'h33330000;
        repeat (3) @(negedge clk);
        in_valid = 0;
        chk("R7 no overwrite", wr_cnt - snap, 0);
        chk("R9 irq held", irq, 1);
        chk("R9 count held", word_count, 4);
        // R8 resume at base; ack without pending ignored
        pulse_ack();
        push(MYBUS, 32'h44440000);
        pulse_ack();
        push(MYBUS, 32'h44440001);
        @(negedge clk);
        chk("R6 one idle cycle", irq, 0);
        @(negedge clk);
        chk("R6 idle irq", irq, 1);
        chk("R8 count after stray ack", word_count, 2);
        chk("R8 resume at base", cap[8'h80], 32'h44440000);
        chk("R8 stray ack ignored", cap[8'h81], 32'h44440001);
        pulse_ack();

        // R6 limit zero disables timeout
        do_cfg(MYBUS, 16'h0090, 4, 0);
        push(MYBUS, 32'h55550000);
        push(MYBUS, 32'h55550001);
        repeat (40) @(negedge clk);
        chk("R6 limit zero", irq, 0);
        push(MYBUS, 32'h55550002);
        push(MYBUS, 32'h55550003);
        chk("R5 full after gap", irq_cause, 1);
        chk("R5 count after gap", word_count, 4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule